// File: doc/BRIEF.md
# Single-Precision NaN Resolution Stage

This stage sits after operand fetch in a single-precision floating-point pipeline. For each operation it looks at up to two 32-bit operands and works out whether a NaN is present. When one is, it decides what the operation must produce and whether the Invalid Operation condition is raised.

Its behaviour depends on the operation class: arithmetic, sign manipulation, quiet compare, signalling compare or transfer. For arithmetic it also depends on a default-NaN mode bit. The datapath that follows uses the override word instead of its own result whenever the override indication is set. Compares use the unordered indication. The invalid flag is sticky and is cleared only by software.

One strobe in gives one registered result one clock later. Results for operations without NaNs, rounding and denormals are handled elsewhere.

Top module: `fp_nan_stage`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. It is quiet when fraction bit 22 is 1 and signalling when that bit is 0. An infinity (fraction zero) is not a NaN.
- R2: Arithmetic (op_class 0) in default-NaN mode (dn_mode=1) with any NaN in A or B drives override=1 and result 0x7FC00000, whatever the NaN fractions are.
- R3: Arithmetic in full-compliance mode (dn_mode=0) with a NaN present drives override=1. The result is chosen in this priority: signalling A, then signalling B, then quiet A, then quiet B. A chosen signalling NaN is quieted by setting bit 22, with all other bits kept.
- R4: Arithmetic raises the invalid flag exactly when A or B is a signalling NaN, in either mode.
- R5: Sign manipulation (op_class 1) uses operand A only. If A is a NaN it returns A with the sign bit set by sign_ctl (0 keep, 1 invert, 2 clear, 3 keep) and override=1. It never raises the flag and ignores dn_mode.
- R6: Transfer (op_class 4) uses operand A only. If A is a NaN it returns A bit for bit with override=1, in both modes, and never raises the flag.
- R7: Quiet compare (op_class 2) drives unordered=1 when A or B is a NaN, and raises the flag only when one of them is signalling. It never drives override.
- R8: Signalling compare (op_class 3) drives unordered=1 and raises the flag when A or B is any NaN. It never drives override.
- R9: When no operand that the class uses is a NaN, override, unordered and the result word are 0 and the flag is unchanged. Codes 5 to 7 of op_class behave the same way for any operands.
- R10: res_valid is high for exactly the cycle after each in_valid cycle. override, res_word and unordered are registered with it.
- R11: The invalid flag is ORed with each valid operation's raise condition on the clock edge of that operation. A flag_clear zeroes it on its edge, but a raise on the same edge still sets it. Reset clears the flag and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_class | input | 3 | Operation class code |
| sign_ctl | input | 2 | Sign action for sign manipulation |
| dn_mode | input | 1 | 1 = default-NaN mode, 0 = full compliance |
| flag_clear | input | 1 | Software clear of the invalid flag |
| res_valid | output | 1 | Result registered this cycle |
| override | output | 1 | res_word replaces the datapath result |
| res_word | output | 32 | NaN result word |
| unordered | output | 1 | Compare found a NaN |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The assertions assume that the operand, class and mode inputs are meaningful only in a cycle where in_valid is high. They also assume that a check on the flag's hold or clear behaviour applies only when no new operation can raise it in that cycle. The stimulus gives each operation a single strobe cycle followed by an idle cycle, so every result can be matched to one operation. It drives flag_clear either alone or together with an operation whose raise outcome is known, which keeps each flag transition traceable to a single cause.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_SIGN  = 3'd1,
    CLS_QCMP  = 3'd2,
    CLS_SCMP  = 3'd3,
    CLS_XFER  = 3'd4
  } op_class_e;

  typedef enum logic [1:0] {
    SGN_KEEP  = 2'd0,
    SGN_FLIP  = 2'd1,
    SGN_CLEAR = 2'd2,
    SGN_KEEP2 = 2'd3
  } sign_ctl_e;

  typedef struct packed {
    logic is_nan;
    logic is_qnan;
    logic is_snan;
  } nan_info_t;
endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output nan_info_t    info
);
  logic exp_ones;
  logic frac_nz;
  logic quiet_bit;

  always_comb begin
    exp_ones     = &val[W-2 -: EXP_W];
    frac_nz      = |val[FRAC_W-1:0];
    quiet_bit    = val[FRAC_W-1];
    info.is_nan  = exp_ones && frac_nz;
    info.is_qnan = info.is_nan && quiet_bit;
    info.is_snan = info.is_nan && !quiet_bit;
  end
endmodule

// File: rtl/fpn_decide.sv
module fpn_decide
  import fpn_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  nan_info_t    ia,
  input  nan_info_t    ib,
  input  op_class_e    cls,
  input  sign_ctl_e    sc,
  input  logic         dflt_mode,
  output logic         ovr,
  output logic [W-1:0] word,
  output logic         unord,
  output logic         raise
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] pick_full;
  logic         new_sign;

  always_comb begin
    if (ia.is_snan)      pick_full = a | QBIT;
    else if (ib.is_snan) pick_full = b | QBIT;
    else if (ia.is_qnan) pick_full = a;
    else                 pick_full = b;
  end

  always_comb begin
    unique case (sc)
      SGN_FLIP:  new_sign = ~a[W-1];
      SGN_CLEAR: new_sign = 1'b0;
      default:   new_sign = a[W-1];
    endcase
  end

  always_comb begin
    ovr   = 1'b0;
    word  = '0;
    unord = 1'b0;
    raise = 1'b0;
    unique case (cls)
      CLS_ARITH: begin
        if (ia.is_nan || ib.is_nan) begin
          ovr  = 1'b1;
          word = dflt_mode ? DNAN : pick_full;
        end
        raise = ia.is_snan || ib.is_snan;
      end
      CLS_SIGN: begin
        if (ia.is_nan) begin
          ovr  = 1'b1;
          word = {new_sign, a[W-2:0]};
        end
      end
      CLS_QCMP: begin
        unord = ia.is_nan || ib.is_nan;
        raise = ia.is_snan || ib.is_snan;
      end
      CLS_SCMP: begin
        unord = ia.is_nan || ib.is_nan;
        raise = ia.is_nan || ib.is_nan;
      end
      CLS_XFER: begin
        if (ia.is_nan) begin
          ovr  = 1'b1;
          word = a;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpn_sticky.sv
module fpn_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_en,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !clr) || set_en;
  end
endmodule

// File: rtl/fp_nan_stage.sv
module fp_nan_stage
  import fpn_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int N_OPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [31:0]  op_a,
  input  logic [31:0]  op_b,
  input  logic [2:0]   op_class,
  input  logic [1:0]   sign_ctl,
  input  logic         dn_mode,
  input  logic         flag_clear,
  output logic         res_valid,
  output logic         override,
  output logic [31:0]  res_word,
  output logic         unordered,
  output logic         invalid_flag
);
  logic [W-1:0] opnd [N_OPS];
  nan_info_t    info [N_OPS];

  assign opnd[0] = op_a[W-1:0];
  assign opnd[1] = op_b[W-1:0];

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpn_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val  (opnd[i]),
      .info (info[i])
    );
  end

  logic         d_ovr;
  logic [W-1:0] d_word;
  logic         d_unord;
  logic         d_raise;

  fpn_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
    .a         (opnd[0]),
    .b         (opnd[1]),
    .ia        (info[0]),
    .ib        (info[1]),
    .cls       (op_class_e'(op_class)),
    .sc        (sign_ctl_e'(sign_ctl)),
    .dflt_mode (dn_mode),
    .ovr       (d_ovr),
    .word      (d_word),
    .unord     (d_unord),
    .raise     (d_raise)
  );

  fpn_sticky u_flag (
    .clk    (clk),
    .rst    (rst),
    .clr    (flag_clear),
    .set_en (in_valid && d_raise),
    .flag   (invalid_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      override  <= 1'b0;
      res_word  <= '0;
      unordered <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        override  <= d_ovr;
        res_word  <= 32'(d_word);
        unordered <= d_unord;
      end
    end
  end
endmodule

// File: rtl/fpn_chk.sv
module fpn_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [2:0]  op_class,
  input logic [1:0]  sign_ctl,
  input logic        dn_mode,
  input logic        flag_clear,
  input logic        res_valid,
  input logic        override,
  input logic [31:0] res_word,
  input logic        unordered,
  input logic        invalid_flag
);
  localparam logic [31:0] DNAN = 32'({1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}});

  logic a_nan, b_nan, a_sn, b_sn;
  assign a_nan = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
  assign a_sn  = a_nan && !op_a[FRAC_W-1];
  assign b_sn  = b_nan && !op_b[FRAC_W-1];

  AST_RES_TIMING: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R10

  AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_class == 3'd0 && dn_mode && (a_nan || b_nan)
    |=> override && res_word == DNAN); // R2

  AST_SIGN_BODY: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_class == 3'd1 && a_nan
    |=> override && res_word[30:0] == $past(op_a[30:0])); // R5

  AST_XFER_EXACT: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_class == 3'd4 && a_nan
    |=> override && res_word == $past(op_a)); // R6

  AST_CMP_UNORD: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op_class == 3'd2 || op_class == 3'd3) && (a_nan || b_nan)
    |=> unordered && !override); // R7

  AST_SCMP_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_class == 3'd3 && (a_nan || b_nan) |=> invalid_flag); // R8

  AST_ARITH_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_class == 3'd0 && (a_sn || b_sn) |=> invalid_flag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    invalid_flag && !flag_clear |=> invalid_flag); // R11

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flag_clear && !in_valid |=> !invalid_flag); // R11
endmodule

bind fp_nan_stage fpn_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .op_class(op_class), .sign_ctl(sign_ctl), .dn_mode(dn_mode),
  .flag_clear(flag_clear), .res_valid(res_valid), .override(override),
  .res_word(res_word), .unordered(unordered), .invalid_flag(invalid_flag)
);

// File: tb/tb_fp_nan_stage.sv
module tb_fp_nan_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0]  op_class = '0;
  logic [1:0]  sign_ctl = '0;
  logic        dn_mode = 1'b0;
  logic        flag_clear = 1'b0;
  logic        res_valid, override, unordered, invalid_flag;
  logic [31:0] res_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_nan_stage dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_class(op_class), .sign_ctl(sign_ctl), .dn_mode(dn_mode),
    .flag_clear(flag_clear), .res_valid(res_valid), .override(override),
    .res_word(res_word), .unordered(unordered), .invalid_flag(invalid_flag)
  );

  typedef struct {
    logic        ovr;
    logic [31:0] word;
    logic        unord;
    logic        flag;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  logic mflag = 1'b0;
  bit   done = 1'b0;

  localparam logic [31:0] QN_A   = 32'h7FC12345;
  localparam logic [31:0] QN_B   = 32'hFFC00007;
  localparam logic [31:0] SN_A   = 32'h7F812345;
  localparam logic [31:0] SN_B   = 32'hFF800001;
  localparam logic [31:0] INF    = 32'h7F800000;
  localparam logic [31:0] ONE    = 32'h3F800000;
  localparam logic [31:0] DNAN   = 32'h7FC00000;

  function automatic logic is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic logic is_sn(logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [2:0] cls,
                       input logic [1:0] sc, input logic dm, input logic clr, input string req);
    exp_t e;
    logic raise;
    e.ovr = 0; e.word = '0; e.unord = 0; raise = 0; e.req = req;
    case (cls)
      3'd0: begin
        if (is_nan(a) || is_nan(b)) begin
          e.ovr = 1;
          if (dm) e.word = DNAN;
          else if (is_sn(a)) e.word = a | 32'h0040_0000;
          else if (is_sn(b)) e.word = b | 32'h0040_0000;
          else if (is_nan(a)) e.word = a;
          else e.word = b;
        end
        raise = is_sn(a) || is_sn(b);
      end
      3'd1: if (is_nan(a)) begin
        e.ovr = 1;
        e.word = a;
        if (sc == 2'd1) e.word[31] = ~a[31];
        else if (sc == 2'd2) e.word[31] = 1'b0;
      end
      3'd2: begin e.unord = is_nan(a) || is_nan(b); raise = is_sn(a) || is_sn(b); end
      3'd3: begin e.unord = is_nan(a) || is_nan(b); raise = e.unord; end
      3'd4: if (is_nan(a)) begin e.ovr = 1; e.word = a; end
      default: ;
    endcase
    mflag = (clr ? 1'b0 : mflag) | raise;
    e.flag = mflag;
    @(negedge clk);
    op_a = a; op_b = b; op_class = cls; sign_ctl = sc; dn_mode = dm;
    flag_clear = clr; in_valid = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; flag_clear = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    mflag = 1'b0;
    check("R11", "flag after clear", 32'(invalid_flag), 32'd0);
  endtask

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R10", "unexpected res_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "override", 32'(override), 32'(e.ovr));
        check(e.req, "res_word", res_word, e.word);
        check(e.req, "unordered", 32'(unordered), 32'(e.unord));
        check(e.req, "invalid_flag", 32'(invalid_flag), 32'(e.flag));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state, R10 idle
    check("R11", "flag at reset", 32'(invalid_flag), 32'd0);
    check("R10", "res_valid idle", 32'(res_valid), 32'd0);
    check("R11", "override at reset", 32'(override), 32'd0);

    // R1 / R9: infinity and numbers are not NaN
    do_op(INF, ONE, 3'd0, 2'd0, 1'b0, 1'b0, "R9");
    do_op(INF, INF, 3'd3, 2'd0, 1'b0, 1'b0, "R1");
    do_op(QN_A, ONE, 3'd5, 2'd0, 1'b0, 1'b0, "R9");
    // R2 default mode
    do_op(QN_A, ONE, 3'd0, 2'd0, 1'b1, 1'b0, "R2");
    do_op(ONE, QN_B, 3'd0, 2'd0, 1'b1, 1'b0, "R2");
    // R3 full mode priority
    do_op(QN_A, QN_B, 3'd0, 2'd0, 1'b0, 1'b0, "R3");
    do_op(ONE, QN_B, 3'd0, 2'd0, 1'b0, 1'b0, "R3");
    do_op(QN_A, SN_B, 3'd0, 2'd0, 1'b0, 1'b0, "R3");
    do_clear();
    do_op(SN_A, SN_B, 3'd0, 2'd0, 1'b0, 1'b0, "R3");
    do_clear();
    // R4 default mode with SNaN
    do_op(SN_B, ONE, 3'd0, 2'd0, 1'b1, 1'b0, "R4");
    do_clear();
    // R5 sign operations
    do_op(SN_A, ONE, 3'd1, 2'd0, 1'b1, 1'b0, "R5");
    do_op(SN_B, ONE, 3'd1, 2'd1, 1'b0, 1'b0, "R5");
    do_op(QN_B, ONE, 3'd1, 2'd2, 1'b1, 1'b0, "R5");
    do_op(QN_A, ONE, 3'd1, 2'd3, 1'b0, 1'b0, "R5");
    do_op(ONE, SN_A, 3'd1, 2'd1, 1'b0, 1'b0, "R5");
    // R6 transfer
    do_op(SN_B, SN_A, 3'd4, 2'd0, 1'b0, 1'b0, "R6");
    do_op(QN_B, ONE, 3'd4, 2'd0, 1'b1, 1'b0, "R6");
    // R7 quiet compare
    do_op(ONE, QN_A, 3'd2, 2'd0, 1'b0, 1'b0, "R7");
    do_op(ONE, SN_A, 3'd2, 2'd0, 1'b0, 1'b0, "R7");
    do_clear();
    // R8 signalling compare
    do_op(QN_B, ONE, 3'd3, 2'd0, 1'b0, 1'b0, "R8");
    // R11 sticky through a clean op, then clear with raise
    do_op(ONE, ONE, 3'd0, 2'd0, 1'b0, 1'b0, "R11");
    do_op(SN_A, ONE, 3'd2, 2'd0, 1'b0, 1'b1, "R11");
    do_op(ONE, ONE, 3'd2, 2'd0, 1'b0, 1'b1, "R11");

    repeat (3) @(negedge clk);
    check("R10", "pending results", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule